// File: doc/BRIEF.md
# Rotating register window controller

This block owns the register window state of a processor core that uses overlapping register windows: a physical register file of `NAREG` entries of which sixteen are visible at a time. It holds the current window base (a count of four-register groups, kept modulo `NAREG/4`) and a start vector with one bit per group that marks which groups begin a live call frame. It translates logical register indices from the datapath into physical ones, and it carries out window-control commands: the procedure-entry allocation, the windowed return, a plain rotation, a stack-pointer move check, a direct base write and a base restore from the saved old-base field.

Each command arrives on a valid/ready stream with the operands the datapath already holds: the source register value for an entry, register a0 for a return, the new base or rotation amount otherwise. The command updates the window state at the edge where it is accepted. Its outcome is registered and offered on a result stream. The outcome is a kind code, a size code, the PC to record or return to, and the old base. The core uses it to continue, to raise an illegal-instruction or alloca cause, or to enter a spill/fill handler. The processor status fields (window-overflow enable, exception mode, call increment, saved old base) are plain inputs. Back-pressure works as follows. While a result is held and the result stream is not ready, `cmd_ready` is low, no command is taken, and the result outputs do not change. A result is consumed on any cycle where `res_valid` and `res_ready` are both high.

Top module: `wrf_window_ctrl`

## Requirements
- R1: After reset the window base is 0, the start vector has only bit 0 set, `res_valid` is low and `cmd_ready` is high.
- R2: Logical register r (0..15), for reads on both ports and for external writes, addresses physical register (base*4 + r) mod NAREG. The base wraps modulo NAREG/4.
- R3: An entry (op 0) is illegal when the register field `cmd_sreg` exceeds 3, when `ps_woe` is low, or when `ps_excm` is high. An illegal entry reports kind 1, writes no register and leaves base and start vector unchanged.
- R4: The legal entry check forms a rotated vector v, where v[i] is start bit (base+1+i) mod NAREG/4. If none of the low `ps_callinc` bits of v is set, the entry writes operand minus `cmd_imm` to logical register callinc*4+s of the pre-rotation window. It then advances the base by callinc, sets the start bit of the new base, and reports kind 0.
- R5: If some of the low `ps_callinc` bits of v is set, the entry reports overflow (kind 3) instead. The base advances by n, the trailing-zero count of v plus one. The start vector is unchanged, no register is written, `res_owb` gives the old base and `res_pc` gives `cmd_pc`.
- R6: The overflow size code comes from the trailing-zero count of v shifted right by n: a count of 0 gives code 1 (four registers), 1 gives code 2 (eight), and anything larger gives code 3 (twelve).
- R7: A return (op 1) takes n from operand bits 31:30. It takes m as 1, 2 or 3 for the first set start bit at base-1, base-2, base-3 (checked in that order), and m is 0 if none is set. It is illegal (kind 1, no state change) when n is 0, when m is nonzero and differs from n, when `ps_woe` is low, or when `ps_excm` is high.
- R8: A legal return whose target group (base-n) has its start bit set moves the base back by n, clears the start bit of the old base and reports kind 0 with `res_pc` equal to `cmd_pc` bits 31:30 joined to operand bits 29:0.
- R9: A legal return whose target group has its start bit clear reports underflow (kind 4) with size code n. It moves the base back by n, leaves the start vector unchanged, and gives `res_owb` as the old base and `res_pc` as `cmd_pc`.
- R10: The stack-move check (op 3) reports alloca (kind 2) when none of the start bits at base-1, base-2, base-3 is set, and kind 0 otherwise. It never changes base or start vector.
- R11: Rotation (op 2) adds operand bits 3:0, taken as a signed amount, to the base. The base write (op 4) loads the operand's low bits. The restore (op 5) loads `ps_owb`. Ops 6 and 7 change nothing.
- R12: While `res_valid` is high and `res_ready` is low, `cmd_ready` is low, no command changes the window state, and the result outputs hold their values.
- R13: An external write in the cycle a command is accepted is mapped with the pre-command base. If that command is a legal entry that writes a register, the entry's write takes the single write port and the external write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | 0 entry, 1 return, 2 rotate, 3 stack-move check, 4 base write, 5 restore |
| cmd_sreg | input | 4 | Entry source register field |
| cmd_imm | input | XLEN | Entry frame size to subtract |
| cmd_opnd | input | XLEN | Entry source value, return a0, rotation amount or new base |
| cmd_pc | input | XLEN | PC of the command |
| ps_woe | input | 1 | Window-overflow enable status bit |
| ps_excm | input | 1 | Exception-mode status bit |
| ps_callinc | input | 2 | Call increment in groups of four |
| ps_owb | input | WBW | Saved old base, used by restore |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken when high with res_valid |
| res_kind | output | 3 | 0 ok, 1 illegal, 2 alloca, 3 overflow, 4 underflow |
| res_size | output | 2 | 1, 2, 3 for four, eight, twelve registers; 0 otherwise |
| res_pc | output | XLEN | Return PC or PC to record |
| res_owb | output | WBW | Base before the command |
| window_base | output | WBW | Current window base |
| window_start | output | NW | Current start vector |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | XLEN | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | XLEN | Read data, port B |
| wr_en | input | 1 | External register write enable |
| wr_idx | input | 4 | Logical index of the external write |
| wr_data | input | XLEN | External write data |

## Verification
The two functions that can coincide are the datapath's register write and a window command. Both act on the same edge and compete for the same base and the same write port. The bench raises `wr_en` in the very cycle it offers an entry that writes a register, and again alongside a rotation. It then reads the register file back through the ports after moving the window. The entry's value must be present where the external value was aimed, and the rotation's companion write must sit in the group reached by the pre-rotation base. Overflow and underflow cases are set up by building start vectors with chosen gaps through successive entries and base writes, so that each size code and each rotation amount is produced from a known vector.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  typedef enum logic [2:0] {
    OP_ENTRY   = 3'd0,
    OP_RETW    = 3'd1,
    OP_ROTATE  = 3'd2,
    OP_SPCHECK = 3'd3,
    OP_BASESET = 3'd4,
    OP_RESTORE = 3'd5
  } wop_e;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_ILLEGAL   = 3'd1,
    RES_ALLOCA    = 3'd2,
    RES_OVERFLOW  = 3'd3,
    RES_UNDERFLOW = 3'd4
  } wres_e;

endpackage

// File: rtl/wrf_idx_map.sv
module wrf_idx_map #(
  parameter int WBW = 4,
  localparam int PW = WBW + 2
) (
  input  logic [WBW-1:0] wb,
  input  logic [3:0]     lidx,
  output logic [PW-1:0]  pidx
);
  // group base times four, plus the logical offset, wrapping at NAREG
  assign pidx = {wb, 2'b00} + PW'(lidx);
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile #(
  parameter int NAREG = 64,
  parameter int XLEN  = 32,
  localparam int PW   = $clog2(NAREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   ra_a,
  input  logic [PW-1:0]   ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [PW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] mem [NAREG];

  for (genvar g = 0; g < NAREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                        mem[g] <= '0;
      else if (we && (wa == PW'(g)))     mem[g] <= wd;
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/wrf_window_logic.sv
module wrf_window_logic
  import wrf_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int XLEN  = 32,
  localparam int NW   = NAREG / 4,
  localparam int WBW  = $clog2(NW),
  localparam int CW   = WBW + 1
) (
  input  logic [2:0]      op,
  input  logic [WBW-1:0]  wb,
  input  logic [NW-1:0]   ws,
  input  logic            ps_woe,
  input  logic            ps_excm,
  input  logic [1:0]      ps_callinc,
  input  logic [WBW-1:0]  ps_owb,
  input  logic [3:0]      sreg,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] opnd,
  input  logic [XLEN-1:0] pc,
  output logic [WBW-1:0]  wb_nxt,
  output logic [NW-1:0]   ws_nxt,
  output wres_e           kind,
  output logic [1:0]      size,
  output logic [XLEN-1:0] res_pc,
  output logic            ent_we,
  output logic [3:0]      ent_idx,
  output logic [XLEN-1:0] ent_data
);
  logic [NW-1:0]  rv;        // start vector seen from base+1
  logic [CW-1:0]  tz0;       // first set bit of rv
  logic [CW-1:0]  novf;      // overflow rotation amount
  logic [CW-1:0]  tz1;       // first set bit at or above novf
  logic [CW-1:0]  gap;
  logic           ovf;
  logic           win_ok;
  logic [1:0]     ret_n;
  logic [1:0]     ret_m;
  logic [WBW-1:0] ret_wb;
  logic [WBW-1:0] wb_m1, wb_m2, wb_m3;

  assign win_ok = ps_woe && !ps_excm;
  assign wb_m1  = wb - WBW'(1);
  assign wb_m2  = wb - WBW'(2);
  assign wb_m3  = wb - WBW'(3);
  assign ret_n  = opnd[XLEN-1 -: 2];
  assign ret_wb = wb - WBW'(ret_n);

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      rv[i] = ws[wb + WBW'(1) + WBW'(i)];
    end
    tz0 = CW'(NW);
    for (int i = NW - 1; i >= 0; i--) begin
      if (rv[i]) tz0 = CW'(i);
    end
    novf = tz0 + CW'(1);
    tz1  = CW'(NW);
    for (int j = NW - 1; j >= 0; j--) begin
      if (rv[j] && (CW'(j) >= novf)) tz1 = CW'(j);
    end
    gap = tz1 - novf;
    ovf = (ps_callinc != 2'd0) && (tz0 < CW'(ps_callinc));
  end

  always_comb begin
    if (ws[wb_m1])      ret_m = 2'd1;
    else if (ws[wb_m2]) ret_m = 2'd2;
    else if (ws[wb_m3]) ret_m = 2'd3;
    else                ret_m = 2'd0;
  end

  always_comb begin
    wb_nxt   = wb;
    ws_nxt   = ws;
    kind     = RES_OK;
    size     = 2'd0;
    res_pc   = pc;
    ent_we   = 1'b0;
    ent_idx  = {ps_callinc, sreg[1:0]};
    ent_data = opnd - imm;
    case (op)
      OP_ENTRY: begin
        if ((sreg > 4'd3) || !win_ok) begin
          kind = RES_ILLEGAL;
        end else if (ovf) begin
          kind   = RES_OVERFLOW;
          wb_nxt = wb + WBW'(novf);
          if (gap == CW'(0))      size = 2'd1;
          else if (gap == CW'(1)) size = 2'd2;
          else                    size = 2'd3;
        end else begin
          ent_we = 1'b1;
          wb_nxt = wb + WBW'(ps_callinc);
          ws_nxt[wb + WBW'(ps_callinc)] = 1'b1;
        end
      end
      OP_RETW: begin
        if ((ret_n == 2'd0) || ((ret_m != 2'd0) && (ret_m != ret_n)) || !win_ok) begin
          kind = RES_ILLEGAL;
        end else begin
          wb_nxt = ret_wb;
          if (ws[ret_wb]) begin
            ws_nxt[wb] = 1'b0;
            res_pc     = {pc[XLEN-1 -: 2], opnd[XLEN-3:0]};
          end else begin
            kind = RES_UNDERFLOW;
            size = ret_n;
          end
        end
      end
      OP_ROTATE:  wb_nxt = wb + opnd[WBW-1:0];
      OP_SPCHECK: if (!(ws[wb_m1] || ws[wb_m2] || ws[wb_m3])) kind = RES_ALLOCA;
      OP_BASESET: wb_nxt = opnd[WBW-1:0];
      OP_RESTORE: wb_nxt = ps_owb;
      default: ;
    endcase
  end
endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl
  import wrf_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int XLEN  = 32,
  localparam int NW   = NAREG / 4,
  localparam int WBW  = $clog2(NW),
  localparam int PW   = WBW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [3:0]      cmd_sreg,
  input  logic [XLEN-1:0] cmd_imm,
  input  logic [XLEN-1:0] cmd_opnd,
  input  logic [XLEN-1:0] cmd_pc,
  input  logic            ps_woe,
  input  logic            ps_excm,
  input  logic [1:0]      ps_callinc,
  input  logic [WBW-1:0]  ps_owb,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [2:0]      res_kind,
  output logic [1:0]      res_size,
  output logic [XLEN-1:0] res_pc,
  output logic [WBW-1:0]  res_owb,
  output logic [WBW-1:0]  window_base,
  output logic [NW-1:0]   window_start,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data
);
  logic [WBW-1:0]  wb_q, wb_nxt;
  logic [NW-1:0]   ws_q, ws_nxt;
  wres_e           kind_c;
  logic [1:0]      size_c;
  logic [XLEN-1:0] pc_c;
  logic            ent_we;
  logic [3:0]      ent_idx;
  logic [XLEN-1:0] ent_data;
  logic            fire;
  logic            rf_we;
  logic [3:0]      rf_lidx;
  logic [XLEN-1:0] rf_wd;
  logic [3:0]      map_in  [3];
  logic [PW-1:0]   map_out [3];

  assign cmd_ready = !res_valid || res_ready;
  assign fire      = cmd_valid && cmd_ready;

  wrf_window_logic #(.NAREG(NAREG), .XLEN(XLEN)) u_logic (
    .op(cmd_op), .wb(wb_q), .ws(ws_q),
    .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc), .ps_owb(ps_owb),
    .sreg(cmd_sreg), .imm(cmd_imm), .opnd(cmd_opnd), .pc(cmd_pc),
    .wb_nxt(wb_nxt), .ws_nxt(ws_nxt), .kind(kind_c), .size(size_c), .res_pc(pc_c),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_data(ent_data)
  );

  // single write port: an accepted entry write displaces the external one
  always_comb begin
    if (fire && ent_we) begin
      rf_we = 1'b1; rf_lidx = ent_idx; rf_wd = ent_data;
    end else begin
      rf_we = wr_en; rf_lidx = wr_idx; rf_wd = wr_data;
    end
  end

  assign map_in[0] = rd_a_idx;
  assign map_in[1] = rd_b_idx;
  assign map_in[2] = rf_lidx;

  for (genvar g = 0; g < 3; g++) begin : g_map
    wrf_idx_map #(.WBW(WBW)) u_map (.wb(wb_q), .lidx(map_in[g]), .pidx(map_out[g]));
  end

  wrf_regfile #(.NAREG(NAREG), .XLEN(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(map_out[0]), .ra_b(map_out[1]), .rd_a(rd_a_data), .rd_b(rd_b_data),
    .we(rf_we), .wa(map_out[2]), .wd(rf_wd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_q      <= '0;
      ws_q      <= NW'(1);
      res_valid <= 1'b0;
      res_kind  <= '0;
      res_size  <= '0;
      res_pc    <= '0;
      res_owb   <= '0;
    end else if (fire) begin
      wb_q      <= wb_nxt;
      ws_q      <= ws_nxt;
      res_valid <= 1'b1;
      res_kind  <= kind_c;
      res_size  <= size_c;
      res_pc    <= pc_c;
      res_owb   <= wb_q;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign window_base  = wb_q;
  assign window_start = ws_q;
endmodule

// File: rtl/wrf_window_checker.sv
module wrf_window_checker #(
  parameter int NAREG = 64,
  parameter int XLEN  = 32,
  localparam int NW   = NAREG / 4,
  localparam int WBW  = $clog2(NW)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic [XLEN-1:0] cmd_opnd,
  input logic            res_valid,
  input logic            res_ready,
  input logic [2:0]      res_kind,
  input logic [1:0]      res_size,
  input logic [WBW-1:0]  window_base,
  input logic [NW-1:0]   window_start
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  assert_start_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    window_start != '0);

  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_kind) && $stable(res_size)));

  assert_state_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> ($stable(window_base) && $stable(window_start)));

  // illegal (R3, R7) and alloca (R10) outcomes leave the window untouched
  assert_reject_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (((res_kind == 3'd1) || (res_kind == 3'd2)) ->
              ($stable(window_base) && $stable(window_start))));

  assert_spill_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ((res_kind == 3'd3) || (res_kind == 3'd4))) |-> (res_size != 2'd0));

  assert_underflow_keeps_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((res_kind == 3'd4) -> $stable(window_start)));

  assert_rotate_amount_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cmd_op == 3'd2)) |=>
      (window_base == WBW'($past(window_base) + $past(cmd_opnd[WBW-1:0]))));
endmodule

bind wrf_window_ctrl wrf_window_checker #(.NAREG(NAREG), .XLEN(XLEN)) u_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_opnd(cmd_opnd), .res_valid(res_valid), .res_ready(res_ready),
  .res_kind(res_kind), .res_size(res_size),
  .window_base(window_base), .window_start(window_start)
);

// File: tb/wrf_window_ctrl_bench.sv
module wrf_window_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NAREG = 64;
  localparam int XLEN  = 32;
  localparam int NW    = NAREG / 4;
  localparam int WBW   = $clog2(NW);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid;
  logic            cmd_ready;
  logic [2:0]      cmd_op;
  logic [3:0]      cmd_sreg;
  logic [XLEN-1:0] cmd_imm, cmd_opnd, cmd_pc;
  logic            ps_woe, ps_excm;
  logic [1:0]      ps_callinc;
  logic [WBW-1:0]  ps_owb;
  logic            res_valid, res_ready;
  logic [2:0]      res_kind;
  logic [1:0]      res_size;
  logic [XLEN-1:0] res_pc;
  logic [WBW-1:0]  res_owb;
  logic [WBW-1:0]  window_base;
  logic [NW-1:0]   window_start;
  logic [3:0]      rd_a_idx, rd_b_idx, wr_idx;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data;
  logic            wr_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wrf_window_ctrl #(.NAREG(NAREG), .XLEN(XLEN)) u_wrf_window_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sreg(cmd_sreg), .cmd_imm(cmd_imm), .cmd_opnd(cmd_opnd),
    .cmd_pc(cmd_pc), .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc),
    .ps_owb(ps_owb), .res_valid(res_valid), .res_ready(res_ready),
    .res_kind(res_kind), .res_size(res_size), .res_pc(res_pc), .res_owb(res_owb),
    .window_base(window_base), .window_start(window_start),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
    .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_sreg = '0; cmd_imm = '0;
    cmd_opnd = '0; cmd_pc = '0; ps_woe = 1'b1; ps_excm = 1'b0; ps_callinc = 2'd0;
    ps_owb = '0; res_ready = 1'b1; rd_a_idx = '0; rd_b_idx = '0; wr_en = 1'b0;
    wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue_w(input logic [2:0] op, input logic [3:0] s, input logic [31:0] imm,
                         input logic [31:0] opnd, input logic [31:0] pc,
                         input logic we, input logic [3:0] widx, input logic [31:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sreg = s; cmd_imm = imm; cmd_opnd = opnd; cmd_pc = pc;
    wr_en = we; wr_idx = widx; wr_data = wd;
    @(negedge clk);
    cmd_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [3:0] s, input logic [31:0] imm,
                       input logic [31:0] opnd, input logic [31:0] pc);
    issue_w(op, s, imm, opnd, pc, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic ext_write(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_a(input logic [3:0] idx, output logic [31:0] d);
    rd_a_idx = idx; #1; d = rd_a_data;
  endtask

  task automatic read_b(input logic [3:0] idx, output logic [31:0] d);
    rd_b_idx = idx; #1; d = rd_b_data;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 base", 32'(window_base), 32'd0);
    check("R1 start", 32'(window_start), 32'd1);
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    do_reset();
    ext_write(4'd3, 32'h33);                 // phys 3
    issue(3'd2, 4'd0, 0, 32'd1, 0);          // rotate +1
    check("R2 rotate base", 32'(window_base), 32'd1);
    read_a(4'd3, d); check("R2 fresh phys7", d, 32'd0);
    ext_write(4'd3, 32'h77);                 // phys 7
    issue(3'd2, 4'd0, 0, 32'hF, 0);          // rotate -1
    check("R11 rotate back", 32'(window_base), 32'd0);
    read_b(4'd7, d); check("R2 port B phys7", d, 32'h77);
    read_a(4'd3, d); check("R2 phys3", d, 32'h33);
    issue(3'd4, 4'd0, 0, 32'd15, 0);         // base write 15
    check("R11 base write", 32'(window_base), 32'd15);
    ext_write(4'd5, 32'hAB);                 // (60+5) mod 64 = phys 1
    issue(3'd4, 4'd0, 0, 32'd0, 0);
    read_a(4'd1, d); check("R2 wrap phys1", d, 32'hAB);
  endtask

  task automatic t_entry_ok();
    logic [31:0] d;
    do_reset();
    ps_callinc = 2'd1;
    issue(3'd0, 4'd1, 32'h10, 32'h1000, 32'h400);
    check("R4 kind", 32'(res_kind), 32'd0);
    check("R4 base", 32'(window_base), 32'd1);
    check("R4 start", 32'(window_start), 32'h3);
    read_a(4'd1, d); check("R4 written sp", d, 32'hFF0);   // phys 5
    read_a(4'd5, d); check("R4 other untouched", d, 32'd0);
  endtask

  task automatic t_entry_illegal();
    logic [31:0] d;
    do_reset();
    ps_callinc = 2'd1; ps_excm = 1'b1;
    issue(3'd0, 4'd1, 32'h10, 32'h1000, 0);
    check("R3 excm kind", 32'(res_kind), 32'd1);
    ps_excm = 1'b0; ps_woe = 1'b0;
    issue(3'd0, 4'd1, 32'h10, 32'h1000, 0);
    check("R3 woe kind", 32'(res_kind), 32'd1);
    ps_woe = 1'b1;
    issue(3'd0, 4'd4, 32'h10, 32'h1000, 0);
    check("R3 field kind", 32'(res_kind), 32'd1);
    check("R3 base", 32'(window_base), 32'd0);
    check("R3 start", 32'(window_start), 32'd1);
    read_a(4'd5, d); check("R3 no write", d, 32'd0);
  endtask

  task automatic t_overflow();
    // overflow with n=2 and size code 1
    do_reset();
    ps_callinc = 2'd1;
    issue(3'd0, 4'd0, 0, 0, 0);
    issue(3'd0, 4'd0, 0, 0, 0);              // base 2, start 0b111
    issue(3'd4, 4'd0, 0, 32'd14, 0);
    ps_callinc = 2'd3;
    issue(3'd0, 4'd0, 0, 0, 32'h800);
    check("R5 kind", 32'(res_kind), 32'd3);
    check("R5 base by n", 32'(window_base), 32'd0);
    check("R5 start kept", 32'(window_start), 32'h7);
    check("R5 owb", 32'(res_owb), 32'd14);
    check("R5 pc", res_pc, 32'h800);
    check("R6 size4", 32'(res_size), 32'd1);
    ps_owb = 4'd14;
    issue(3'd5, 4'd0, 0, 0, 0);
    check("R11 restore", 32'(window_base), 32'd14);
    // size code 2
    do_reset();
    ps_callinc = 2'd2; issue(3'd0, 4'd0, 0, 0, 0);
    ps_callinc = 2'd1; issue(3'd0, 4'd0, 0, 0, 0);   // start 0b1101
    issue(3'd4, 4'd0, 0, 32'd15, 0);
    ps_callinc = 2'd3; issue(3'd0, 4'd0, 0, 0, 0);
    check("R6 size8 kind", 32'(res_kind), 32'd3);
    check("R6 size8", 32'(res_size), 32'd2);
    check("R5 base n1", 32'(window_base), 32'd0);
    // size code 3 with callinc 1
    do_reset();
    ps_callinc = 2'd3; issue(3'd0, 4'd0, 0, 0, 0);   // start 0b1001
    issue(3'd4, 4'd0, 0, 32'd15, 0);
    ps_callinc = 2'd1; issue(3'd0, 4'd0, 0, 0, 0);
    check("R6 size12 kind", 32'(res_kind), 32'd3);
    check("R6 size12", 32'(res_size), 32'd3);
  endtask

  task automatic t_retw();
    do_reset();
    ps_callinc = 2'd2; issue(3'd0, 4'd0, 0, 0, 0);   // base 2, start 0b101
    issue(3'd1, 4'd0, 0, 32'h4000_0000, 0);
    check("R7 mismatch", 32'(res_kind), 32'd1);
    issue(3'd1, 4'd0, 0, 32'h0000_1234, 0);
    check("R7 n zero", 32'(res_kind), 32'd1);
    ps_excm = 1'b1;
    issue(3'd1, 4'd0, 0, 32'h8000_1234, 0);
    check("R7 excm", 32'(res_kind), 32'd1);
    check("R7 base kept", 32'(window_base), 32'd2);
    ps_excm = 1'b0;
    issue(3'd1, 4'd0, 0, 32'h8000_1234, 32'hC000_0100);
    check("R8 kind", 32'(res_kind), 32'd0);
    check("R8 base", 32'(window_base), 32'd0);
    check("R8 start", 32'(window_start), 32'd1);
    check("R8 ret pc", res_pc, 32'hC000_1234);
  endtask

  task automatic t_underflow();
    do_reset();
    ps_callinc = 2'd2; issue(3'd0, 4'd0, 0, 0, 0);
    ps_callinc = 2'd1; issue(3'd0, 4'd0, 0, 0, 0);   // start 0b1101
    issue(3'd4, 4'd0, 0, 32'd8, 0);
    issue(3'd1, 4'd0, 0, 32'hC000_0000, 32'h900);
    check("R9 kind", 32'(res_kind), 32'd4);
    check("R9 size", 32'(res_size), 32'd3);
    check("R9 base", 32'(window_base), 32'd5);
    check("R9 start", 32'(window_start), 32'hD);
    check("R9 owb", 32'(res_owb), 32'd8);
    check("R9 pc", res_pc, 32'h900);
  endtask

  task automatic t_spcheck();
    do_reset();
    issue(3'd3, 4'd0, 0, 0, 0);
    check("R10 alloca", 32'(res_kind), 32'd2);
    check("R10 base", 32'(window_base), 32'd0);
    ps_callinc = 2'd1; issue(3'd0, 4'd0, 0, 0, 0);
    issue(3'd3, 4'd0, 0, 0, 0);
    check("R10 ok", 32'(res_kind), 32'd0);
    issue(3'd6, 4'd0, 0, 32'd5, 0);
    check("R11 op6 base", 32'(window_base), 32'd1);
    check("R11 op6 start", 32'(window_start), 32'h3);
  endtask

  task automatic t_backpressure();
    do_reset();
    res_ready = 1'b0;
    issue(3'd2, 4'd0, 0, 32'd2, 0);
    check("R12 result up", 32'(res_valid), 32'd1);
    check("R12 base", 32'(window_base), 32'd2);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_opnd = 32'd3;
    @(negedge clk);
    check("R12 not ready", 32'(cmd_ready), 32'd0);
    check("R12 kind held", 32'(res_kind), 32'd0);
    @(negedge clk);
    check("R12 base frozen", 32'(window_base), 32'd2);
    cmd_valid = 1'b0; res_ready = 1'b1;
    @(negedge clk);
    check("R12 drained", 32'(res_valid), 32'd0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    do_reset();
    ps_callinc = 2'd1;
    issue_w(3'd0, 4'd0, 32'd1, 32'h100, 0, 1'b1, 4'd4, 32'hDEAD);  // both aim phys 4
    read_a(4'd0, d); check("R13 entry wins", d, 32'hFF);
    issue_w(3'd2, 4'd0, 0, 32'd1, 0, 1'b1, 4'd2, 32'hBEEF);         // old base 1: phys 6
    read_a(4'd2, d); check("R13 not in new window", d, 32'd0);
    issue(3'd2, 4'd0, 0, 32'hF, 0);
    read_a(4'd2, d); check("R13 old window", d, 32'hBEEF);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_mapping();
    t_entry_ok();
    t_entry_illegal();
    t_overflow();
    t_retw();
    t_underflow();
    t_spcheck();
    t_backpressure();
    t_same_cycle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule